// File: doc/BRIEF.md
# Integer Add, Logic and Byte ALU

This block is the combinational execution stage for register-operate instructions of two integer groups: an arithmetic group and a logical group. It takes a 6-bit major opcode, a 7-bit function code, a 64-bit first operand and a second operand. The second operand is either a 64-bit register value or an 8-bit literal that is zero-extended to 64 bits. It returns a 64-bit result together with three flags: the encoding was accepted, a longword add overflowed, or the function code is not defined for the group.

The arithmetic group offers two longword adds, one plain and one with an overflow trap, and a per-lane unsigned byte comparison that packs its eight outcomes into a bitmask. The logical group offers six bitwise functions, three of which complement the second operand, and a byte-lane masking operation that is steered by the low bits of the second operand. Every output settles within the cycle in which the inputs are applied. There is no internal state.

Top module: `int_alu_unit`

## Requirements
- R1: Opcode 0x10 selects the arithmetic group and opcode 0x11 selects the logical group. Any other opcode drives result 0, valid 0, trap 0 and illegal 0.
- R2: Arithmetic function 0x00 adds bits 31:0 of both operands modulo 2^32 and returns the 32-bit sum sign-extended from bit 31 to 64 bits.
- R3: Arithmetic function 0x40 returns the same result as R2. The trap flag is 1 exactly when bit 31 of both operands matches and bit 31 of the 32-bit sum differs from bit 31 of operand A.
- R4: Arithmetic function 0x0F sets result bit i (i = 0..7) when byte lane i of A, taken as unsigned, is greater than or equal to byte lane i of the second operand. Result bits 63:8 are 0.
- R5: Logical function 0x31 passes byte lane i of A to the result when bit i of the second operand is 1, and drives that lane to 0 when the bit is 0.
- R6: The logical functions are 0x00 A&B, 0x08 A&~B, 0x20 A|B, 0x28 A|~B, 0x40 A^B and 0x48 A^~B.
- R7: Every encoding listed in R2 to R6 drives valid 1 and illegal 0. Valid and illegal are never both 1.
- R8: The trap flag is 0 for every encoding other than opcode 0x10 with function 0x40.
- R9: A function code not listed for opcode 0x10 or 0x11 drives illegal 1, valid 0, trap 0 and result 0.
- R10: When the literal select is 1, the second operand is the 8-bit literal zero-extended to 64 bits for every operation, the byte mask included, and the register operand has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Major opcode |
| func_i | input | 7 | Function code within the group |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Register form of the second operand |
| lit_sel_i | input | 1 | 1 selects the literal as the second operand |
| lit_i | input | 8 | 8-bit literal |
| result_o | output | 64 | Operation result |
| valid_o | output | 1 | Encoding accepted |
| ovf_trap_o | output | 1 | Trapping longword add overflowed |
| illegal_o | output | 1 | Function code undefined for the group |

## Verification
The hardest case to reach is the overflow trap of the trapping longword add. It fires only at the sign boundary of the low word, and only when the operands' upper 32 bits play no part. The stimulus therefore uses operands whose upper halves are set to opposite garbage and whose low words are chosen at 0x7FFFFFFF+1, 0x80000000+0xFFFFFFFF, and at mixed-sign pairs that sit just short of the limit. A second hard case is a literal feeding the byte mask: its upper mask bits are always 0, so upper lanes of A must vanish even when the register operand is all ones.

// File: rtl/iala_pkg.sv
package iala_pkg;
  localparam int OPC_W  = 6;
  localparam int FUNC_W = 7;

  localparam logic [OPC_W-1:0]  OPC_ARITH = 6'h10;
  localparam logic [OPC_W-1:0]  OPC_LOGIC = 6'h11;

  localparam logic [FUNC_W-1:0] FN_ADDW   = 7'h00;
  localparam logic [FUNC_W-1:0] FN_ADDWT  = 7'h40;
  localparam logic [FUNC_W-1:0] FN_BYTEGE = 7'h0F;

  localparam logic [FUNC_W-1:0] FN_AND    = 7'h00;
  localparam logic [FUNC_W-1:0] FN_ANDN   = 7'h08;
  localparam logic [FUNC_W-1:0] FN_OR     = 7'h20;
  localparam logic [FUNC_W-1:0] FN_ORN    = 7'h28;
  localparam logic [FUNC_W-1:0] FN_XOR    = 7'h40;
  localparam logic [FUNC_W-1:0] FN_XNOR   = 7'h48;
  localparam logic [FUNC_W-1:0] FN_BYTEMSK = 7'h31;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ADD,
    SEL_BYTEGE,
    SEL_LOGIC,
    SEL_BYTEMSK
  } res_sel_e;
endpackage

// File: rtl/iala_lw_add.sv
module iala_lw_add #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              ovf_o
);
  function automatic logic [WORD_W-1:0] add_word(input logic [WORD_W-1:0] x,
                                                 input logic [WORD_W-1:0] y);
    return x + y;
  endfunction

  function automatic logic sign_ovf(input logic [WORD_W-1:0] x,
                                    input logic [WORD_W-1:0] y,
                                    input logic [WORD_W-1:0] s);
    return (x[WORD_W-1] == y[WORD_W-1]) && (s[WORD_W-1] != x[WORD_W-1]);
  endfunction

  logic [WORD_W:0] wide_sum;

  always_comb begin
    sum_o    = add_word(a_i, b_i);
    ovf_o    = sign_ovf(a_i, b_i, sum_o);
    wide_sum = {a_i[WORD_W-1], a_i} + {b_i[WORD_W-1], b_i};
    // R3: the sign-rule flag must agree with a one-bit-wider signed sum
    a_r3_ovf_wide: assert (ovf_o == (wide_sum[WORD_W] != wide_sum[WORD_W-1]))
      else $error("a_r3_ovf_wide: overflow flag disagrees with wide sum");
  end
endmodule

// File: rtl/iala_byte_cmp.sv
module iala_byte_cmp #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int LANES = DATA_W / LANE_W;

  function automatic logic lane_ge(input logic [LANE_W-1:0] x,
                                   input logic [LANE_W-1:0] y);
    return x >= y;
  endfunction

  logic [LANES-1:0] ge_bits;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      ge_bits[g] = lane_ge(a_i[g*LANE_W +: LANE_W], b_i[g*LANE_W +: LANE_W]);
      // R4: equal lanes always compare as greater-or-equal
      a_r4_equal_sets: assert ((a_i[g*LANE_W +: LANE_W] != b_i[g*LANE_W +: LANE_W]) || ge_bits[g])
        else $error("a_r4_equal_sets: equal lane %0d not flagged", g);
    end
  end

  assign y_o = {{(DATA_W-LANES){1'b0}}, ge_bits};
endmodule

// File: rtl/iala_byte_mask.sv
module iala_byte_mask #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int LANES  = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [LANES-1:0]  keep_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W-1:0] clear_mask;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign clear_mask[g*LANE_W +: LANE_W] = {LANE_W{~keep_i[g]}};
  end

  assign y_o = a_i & ~clear_mask;
endmodule

// File: rtl/iala_logic.sv
module iala_logic
  import iala_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [FUNC_W-1:0] func_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o,
  output logic              hit_o
);
  function automatic logic [DATA_W:0] bitwise(input logic [FUNC_W-1:0] f,
                                              input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y);
    logic [DATA_W-1:0] yy;
    yy = f[3] ? ~y : y;
    case (f)
      FN_AND, FN_ANDN: return {1'b1, x & yy};
      FN_OR,  FN_ORN:  return {1'b1, x | yy};
      FN_XOR, FN_XNOR: return {1'b1, x ^ yy};
      default:         return '0;
    endcase
  endfunction

  always_comb begin
    {hit_o, y_o} = bitwise(func_i, a_i, b_i);
  end
endmodule

// File: rtl/int_alu_unit.sv
module int_alu_unit
  import iala_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int LANE_W = 8,
  parameter int LIT_W  = 8
) (
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              lit_sel_i,
  input  logic [LIT_W-1:0]  lit_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              ovf_trap_o,
  output logic              illegal_o
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int EXT_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] b_eff;
  logic [WORD_W-1:0] add_sum;
  logic              add_ovf;
  logic [DATA_W-1:0] cmp_y;
  logic [DATA_W-1:0] msk_y;
  logic [DATA_W-1:0] log_y;
  logic              log_hit;
  res_sel_e          sel;
  logic              is_trap_add;
  logic              is_arith;
  logic              is_logic;

  // R10: the literal is widened with zeros before any operation sees it
  assign b_eff = lit_sel_i ? {{(DATA_W-LIT_W){1'b0}}, lit_i} : op_b_i;

  iala_lw_add #(.WORD_W(WORD_W)) u_add (
    .a_i   (op_a_i[WORD_W-1:0]),
    .b_i   (b_eff[WORD_W-1:0]),
    .sum_o (add_sum),
    .ovf_o (add_ovf)
  );

  iala_byte_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
    .a_i (op_a_i),
    .b_i (b_eff),
    .y_o (cmp_y)
  );

  iala_byte_mask #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES)) u_msk (
    .a_i    (op_a_i),
    .keep_i (b_eff[LANES-1:0]),
    .y_o    (msk_y)
  );

  iala_logic #(.DATA_W(DATA_W)) u_log (
    .func_i (func_i),
    .a_i    (op_a_i),
    .b_i    (b_eff),
    .y_o    (log_y),
    .hit_o  (log_hit)
  );

  // decode of group and function
  always_comb begin
    is_arith    = (opcode_i == OPC_ARITH);
    is_logic    = (opcode_i == OPC_LOGIC);
    is_trap_add = 1'b0;
    sel         = SEL_NONE;
    illegal_o   = 1'b0;
    if (is_arith) begin
      case (func_i)
        FN_ADDW:   sel = SEL_ADD;
        FN_ADDWT: begin
          sel         = SEL_ADD;
          is_trap_add = 1'b1;
        end
        FN_BYTEGE: sel = SEL_BYTEGE;
        default:   illegal_o = 1'b1;
      endcase
    end else if (is_logic) begin
      if (func_i == FN_BYTEMSK) sel = SEL_BYTEMSK;
      else if (log_hit)         sel = SEL_LOGIC;
      else                      illegal_o = 1'b1;
    end
  end

  // result steering
  always_comb begin
    case (sel)
      SEL_ADD:     result_o = {{EXT_W{add_sum[WORD_W-1]}}, add_sum};
      SEL_BYTEGE:  result_o = cmp_y;
      SEL_LOGIC:   result_o = log_y;
      SEL_BYTEMSK: result_o = msk_y;
      default:     result_o = '0;
    endcase
    valid_o    = (sel != SEL_NONE);
    ovf_trap_o = is_trap_add && add_ovf;
  end

  // checks on the assembled outputs
  always_comb begin
    // R9: an undefined function yields a zero result and no valid
    a_r9_illegal_zero: assert (!illegal_o || (result_o == '0 && !valid_o && !ovf_trap_o))
      else $error("a_r9_illegal_zero: illegal encoding leaked data");
    // R8: only the trapping add may raise the trap
    a_r8_trap_only_addwt: assert (!ovf_trap_o || (opcode_i == OPC_ARITH && func_i == FN_ADDWT))
      else $error("a_r8_trap_only_addwt: trap from wrong encoding");
    // R7: accepted and rejected are exclusive
    a_r7_excl: assert ($onehot0({valid_o, illegal_o}))
      else $error("a_r7_excl: valid and illegal together");
    // R2: longword results are sign-extended
    a_r2_sext: assert (!(valid_o && sel == SEL_ADD) ||
                       result_o[DATA_W-1:WORD_W] == {EXT_W{result_o[WORD_W-1]}})
      else $error("a_r2_sext: longword result not sign-extended");
    // R1: foreign opcodes stay silent
    a_r1_foreign_quiet: assert (is_arith || is_logic ||
                                (!valid_o && !illegal_o && result_o == '0))
      else $error("a_r1_foreign_quiet: foreign opcode produced output");
  end
endmodule

// File: tb/test_int_alu_unit.sv
module test_int_alu_unit;
  logic        clk = 1'b0;
  logic [5:0]  opc = '0;
  logic [6:0]  fn = '0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        lsel = 1'b0;
  logic [7:0]  lit = '0;
  logic [63:0] res;
  logic        vld, trp, ill;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  int_alu_unit i_int_alu_unit (
    .opcode_i (opc), .func_i (fn), .op_a_i (a), .op_b_i (b),
    .lit_sel_i (lsel), .lit_i (lit),
    .result_o (res), .valid_o (vld), .ovf_trap_o (trp), .illegal_o (ill)
  );

  function automatic logic [63:0] ref_add(input logic [63:0] x, input logic [63:0] y);
    longint s;
    s = longint'($signed(x[31:0])) + longint'($signed(y[31:0]));
    return {{32{s[31]}}, s[31:0]};
  endfunction

  function automatic logic ref_ovf(input logic [63:0] x, input logic [63:0] y);
    longint s;
    s = longint'($signed(x[31:0])) + longint'($signed(y[31:0]));
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  function automatic logic [63:0] ref_bge(input logic [63:0] x, input logic [63:0] y);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) r[i] = ((x >> (8*i)) & 64'hFF) >= ((y >> (8*i)) & 64'hFF);
    return r;
  endfunction

  function automatic logic [63:0] ref_msk(input logic [63:0] x, input logic [63:0] y);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (y[i]) r = r | (x & (64'hFF << (8*i)));
    return r;
  endfunction

  task automatic apply(input logic [5:0] o, input logic [6:0] f, input logic [63:0] x,
                       input logic [63:0] y, input logic ls, input logic [7:0] l);
    @(negedge clk);
    opc = o; fn = f; a = x; b = y; lsel = ls; lit = l;
    @(posedge clk);
    #2;
  endtask

  task automatic expect_out(input string req, input logic [63:0] er, input logic ev,
                            input logic et, input logic ei);
    n_chk++;
    if (res !== er || vld !== ev || trp !== et || ill !== ei) begin
      n_bad++;
      $display("FAIL %s: got res=%h v=%b t=%b i=%b, expected res=%h v=%b t=%b i=%b",
               req, res, vld, trp, ill, er, ev, et, ei);
    end
  endtask

  task automatic t_idle;
    #3;
    expect_out("R1 idle opcode 0", 64'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_foreign;
    apply(6'h12, 7'h00, 64'hFFFF_0000_1234_5678, 64'h1, 1'b0, 8'h0);
    expect_out("R1 foreign opcode 0x12", 64'h0, 1'b0, 1'b0, 1'b0);
    apply(6'h3F, 7'h40, 64'h7FFF_FFFF, 64'h1, 1'b0, 8'h0);
    expect_out("R1 foreign opcode 0x3F", 64'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_add;
    logic [63:0] x [4] = '{64'hAAAA_0000_0000_0005, 64'h0000_0001_7FFF_FFFF,
                           64'hFFFF_FFFF_8000_0000, 64'h1234_5678_FFFF_FFFF};
    logic [63:0] y [4] = '{64'h5555_0000_0000_0003, 64'hFFFF_0000_0000_0001,
                           64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001};
    for (int k = 0; k < 4; k++) begin
      apply(6'h10, 7'h00, x[k], y[k], 1'b0, 8'h0);
      expect_out("R2 plain longword add", ref_add(x[k], y[k]), 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_addt;
    logic [63:0] x [5] = '{64'hDEAD_0000_7FFF_FFFF, 64'h0000_BEEF_8000_0000,
                           64'h0000_0000_7FFF_FFFF, 64'h1111_1111_8000_0001,
                           64'h0000_0000_4000_0000};
    logic [63:0] y [5] = '{64'h0000_FFFF_0000_0001, 64'hFFFF_0000_FFFF_FFFF,
                           64'hFFFF_FFFF_8000_0000, 64'h2222_2222_FFFF_FFFF,
                           64'h0000_0000_3FFF_FFFF};
    for (int k = 0; k < 5; k++) begin
      apply(6'h10, 7'h40, x[k], y[k], 1'b0, 8'h0);
      expect_out("R3 trapping longword add", ref_add(x[k], y[k]), 1'b1,
                 ref_ovf(x[k], y[k]), 1'b0);
    end
  endtask

  task automatic t_bytege;
    logic [63:0] x [3] = '{64'h00FF_8080_0102_7F00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
    logic [63:0] y [3] = '{64'h0100_8081_0101_8000, 64'h0, 64'h0000_0000_0000_0001};
    for (int k = 0; k < 3; k++) begin
      apply(6'h10, 7'h0F, x[k], y[k], 1'b0, 8'h0);
      expect_out("R4 byte compare", ref_bge(x[k], y[k]), 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_bytemsk;
    logic [63:0] x = 64'h8877_6655_4433_2211;
    logic [7:0]  m [3] = '{8'hA5, 8'h00, 8'hFF};
    for (int k = 0; k < 3; k++) begin
      apply(6'h11, 7'h31, x, {56'hFFFF_FFFF_FFFF_FF, m[k]}, 1'b0, 8'h0);
      expect_out("R5 byte mask", ref_msk(x, {56'h0, m[k]}), 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_logic;
    logic [6:0]  f [6] = '{7'h00, 7'h08, 7'h20, 7'h28, 7'h40, 7'h48};
    logic [63:0] x = 64'hF0F0_CCCC_AAAA_0F0F;
    logic [63:0] y = 64'hFF00_F0F0_5555_3C3C;
    logic [63:0] e [6];
    e[0] = x & y; e[1] = x & ~y; e[2] = x | y;
    e[3] = x | ~y; e[4] = x ^ y; e[5] = ~(x ^ y);
    for (int k = 0; k < 6; k++) begin
      apply(6'h11, f[k], x, y, 1'b0, 8'h0);
      expect_out("R6 R7 logical function", e[k], 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_illegal;
    logic [6:0] fa [3] = '{7'h01, 7'h7F, 7'h20};
    logic [6:0] fl [3] = '{7'h01, 7'h30, 7'h0F};
    for (int k = 0; k < 3; k++) begin
      apply(6'h10, fa[k], 64'h7FFF_FFFF, 64'h7FFF_FFFF, 1'b0, 8'h0);
      expect_out("R9 R8 undefined arithmetic function", 64'h0, 1'b0, 1'b0, 1'b1);
      apply(6'h11, fl[k], 64'hFFFF, 64'hFFFF, 1'b0, 8'h0);
      expect_out("R9 undefined logical function", 64'h0, 1'b0, 1'b0, 1'b1);
    end
  endtask

  task automatic t_literal;
    logic [63:0] x = 64'hFFEE_DDCC_BBAA_9988;
    logic [63:0] junk = 64'hFFFF_FFFF_FFFF_FFFF;
    apply(6'h11, 7'h31, x, junk, 1'b1, 8'h06);
    expect_out("R10 R5 literal byte mask", 64'h0000_0000_00AA_9900, 1'b1, 1'b0, 1'b0);
    apply(6'h11, 7'h20, 64'h0, junk, 1'b1, 8'h5A);
    expect_out("R10 literal or", 64'h5A, 1'b1, 1'b0, 1'b0);
    apply(6'h11, 7'h08, x, junk, 1'b1, 8'hFF);
    expect_out("R10 literal and-not", x & ~64'hFF, 1'b1, 1'b0, 1'b0);
    apply(6'h10, 7'h40, 64'h7FFF_FFFF, junk, 1'b1, 8'h01);
    expect_out("R10 R3 literal trapping add", 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b1, 1'b0);
    apply(6'h10, 7'h0F, 64'h0000_0000_0000_0010, junk, 1'b1, 8'h10);
    expect_out("R10 R4 literal byte compare", 64'hFF, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    t_idle();
    t_foreign();
    t_add();
    t_addt();
    t_bytege();
    t_bytemsk();
    t_logic();
    t_illegal();
    t_literal();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule